// File: doc/BRIEF.md
# PHY Discovery and Configuration Sequencer

This block finds the transceivers hanging on a management bus and brings each one into a known configuration. A one-cycle start strobe launches a scan. The sequencer walks the management addresses, reads each status register, and decides from a fixed bit-pattern rule whether a transceiver answers there. For every accepted transceiver it reads the control and advertisement registers. It then reconciles the advertisement with a configured value and rewrites the advertisement and control registers only where they need to change. All register traffic passes through a simple request/acknowledge port to a separate management-bus master, which handles the serial timing.

The control register is adjusted for either autonegotiation or a forced speed and duplex. When the autonegotiation enable bit flips, the new control word is written twice. Between the two writes the sequencer waits a parameterised number of microsecond ticks, so that slow transceivers latch the enable change before the forced settings. Found addresses go into a small table of parameterised depth. The scan stops early once the table is full. A single done pulse marks the end, and the count is then final.

Top module: `phy_scan_seq`

## Requirements
- R1: Addresses are probed by a status read (register 1) in the order 1, 2, ..., 31, then 0, one probe per address.
- R2: A status word s accepts a transceiver when (s & 0x8301) == 0x8001, or when s[15] is 0 and s[14:11] is nonzero. Any other status skips the address with no further traffic.
- R3: For an accepted address, the control register (0) is read and then the advertisement register (4). Only registers 0, 1 and 4 are accessed, and register 1 is never written.
- R4: When the advertisement read has bits 8:5 all zero, the working advertisement is {status[15:11] at bits 9:5, bit 0 set, all else 0}.
- R5: A nonzero configured advertisement replaces the working one. Register 4 is written with the result only when it differs from the working value.
- R6: In autonegotiation mode (force_en = 0), the new control word has bit 12 set. If bit 12 was clear in the read value, bit 9 is set as well.
- R7: In the new control word, bits 15, 14, 11, 10 and 7 are cleared. Bit 8 is set to force_fdx and bit 13 to force_spd100. In forced mode, bit 12 is cleared.
- R8: The control register is written only when the new word differs from the read value. If bit 12 changed, the same word is written a second time, no earlier than DELAY_US microsecond ticks after the first write completes.
- R9: Each accepted address is recorded in table order, up to MAX_PHYS entries, and phy_count gives the number recorded. Probing ends right after the entry that fills the table.
- R10: A start clears the table. If a scan records no address and expect_mii is 1, entry 0 reads 1 after the scan.
- R11: done is a one-cycle pulse after the last transaction, and the table and count are final when it is high. A start while busy is ignored.
- R12: A pending request holds its write flag, address, register and write data unchanged until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start-of-scan strobe |
| cfg_adv | input | 16 | Configured advertisement, 0 = use value read |
| force_en | input | 1 | 1 = forced media, 0 = autonegotiation |
| force_spd100 | input | 1 | Control bit 13 value |
| force_fdx | input | 1 | Control bit 8 value |
| expect_mii | input | 1 | Apply fallback address 1 when none found |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| mdio_req | output | 1 | Transaction request, held until acknowledged |
| mdio_wr | output | 1 | 1 = write, 0 = read |
| mdio_phy | output | 5 | Transceiver address |
| mdio_reg | output | 5 | Register address |
| mdio_wdata | output | 16 | Write data |
| mdio_ack | input | 1 | Transaction complete pulse |
| mdio_rdata | input | 16 | Read data, valid with mdio_ack |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Scan-complete pulse |
| phy_count | output | $clog2(MAX_PHYS+1) | Number of addresses recorded |
| phy_list | output | MAX_PHYS*5 | Recorded addresses, entry i at bits 5i+4:5i |

## Verification
Several properties are checked on every cycle. Request fields stay stable while a request is pending, and only legal registers are touched. Each control write carries the enable, duplex, speed and cleared bits that the mode demands. The table never overflows, the delay expires only on a tick, and done lasts one cycle. Other behaviour shows only in the bench's scenarios: the probe order, the acceptance decisions on chosen status words, and whether each write happens at all, including the derived advertisement and the double write. The same holds for the early stop on a full table, the fallback entry and the ignored mid-scan start. A scoreboard compares every management transaction against a queue built from the requirements.

// File: rtl/phy_scan_pkg.sv
package phy_scan_pkg;
  localparam int PHY_AW = 5;
  localparam int REG_AW = 5;
  localparam int WORD_W = 16;

  localparam logic [REG_AW-1:0] REG_CTL  = 5'd0;
  localparam logic [REG_AW-1:0] REG_STAT = 5'd1;
  localparam logic [REG_AW-1:0] REG_ADV  = 5'd4;

  localparam int CTL_AN_EN   = 12;
  localparam int CTL_AN_RST  = 9;
  localparam int CTL_FDX     = 8;
  localparam int CTL_SPD     = 13;
  // loopback, speed, reset, power-down, isolate, duplex, collision test
  localparam logic [WORD_W-1:0] CTL_CLR_MASK  = 16'hE580 | 16'h0800;
  localparam logic [WORD_W-1:0] ADV_TECH_MASK = 16'h01E0;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_STAT, S_RD_CTL, S_RD_ADV, S_DECIDE,
    S_WR_ADV, S_WR_CTL1, S_WAIT, S_WR_CTL2, S_RECORD, S_NEXT, S_FINISH
  } scan_state_e;

  function automatic logic status_ok(input logic [WORD_W-1:0] s);
    return ((s & 16'h8301) == 16'h8001) || (!s[15] && (s[14:11] != 4'd0));
  endfunction
endpackage

// File: rtl/phy_cfg_calc.sv
module phy_cfg_calc
  import phy_scan_pkg::*;
(
  input  logic [4:0]        stat_hi,
  input  logic [WORD_W-1:0] ctl_rd,
  input  logic [WORD_W-1:0] adv_rd,
  input  logic [WORD_W-1:0] cfg_adv,
  input  logic              force_en,
  input  logic              force_spd100,
  input  logic              force_fdx,
  output logic [WORD_W-1:0] adv_out,
  output logic              adv_wr_need,
  output logic [WORD_W-1:0] ctl_out,
  output logic              ctl_wr_need,
  output logic              an_flip
);
  logic [WORD_W-1:0] adv_base;
  logic [WORD_W-1:0] ctl_en;
  logic [WORD_W-1:0] ctl_forced_bits;

  always_comb begin
    if ((adv_rd & ADV_TECH_MASK) == '0)
      adv_base = {6'd0, stat_hi, 4'd0, 1'b1};
    else
      adv_base = adv_rd;
    adv_out     = (cfg_adv != '0) ? cfg_adv : adv_base;
    adv_wr_need = (adv_out != adv_base);
  end

  always_comb begin
    ctl_en = ctl_rd;
    ctl_en[CTL_AN_EN] = !force_en;
    an_flip = (ctl_en != ctl_rd);
    if (!force_en && an_flip)
      ctl_en[CTL_AN_RST] = 1'b1;
    ctl_forced_bits = '0;
    ctl_forced_bits[CTL_FDX] = force_fdx;
    ctl_forced_bits[CTL_SPD] = force_spd100;
    ctl_out     = (ctl_en & ~CTL_CLR_MASK) | ctl_forced_bits;
    ctl_wr_need = (ctl_out != ctl_rd);
  end
endmodule

// File: rtl/phy_tick_delay.sv
module phy_tick_delay #(
  parameter int DELAY_US = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic tick,
  output logic expired
);
  localparam int CW = (DELAY_US < 1) ? 1 : $clog2(DELAY_US + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DELAY_US);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;
  logic          cnt_en;

  assign expired = act_q && (cnt_q == LIMIT);
  assign cnt_en  = load || (tick && act_q && (cnt_q != LIMIT));

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (load) begin
      cnt_d = '0;
      act_d = 1'b1;
    end else if (cnt_en) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  // R8: the wait can only end on a counted tick
  p_expire_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expired) |-> $past(tick));
endmodule

// File: rtl/phy_table.sv
module phy_table
  import phy_scan_pkg::*;
#(
  parameter int MAX_PHYS = 4,
  parameter int CW = $clog2(MAX_PHYS + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       push,
  input  logic [PHY_AW-1:0]          push_addr,
  input  logic                       fallback,
  output logic [MAX_PHYS*PHY_AW-1:0] list,
  output logic [CW-1:0]              count,
  output logic                       full
);
  localparam logic [CW-1:0] CNT_MAX = CW'(MAX_PHYS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign full   = (cnt_q == CNT_MAX);
  assign count  = cnt_q;
  assign cnt_en = clr || (push && !full);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (push && !full)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  for (genvar i = 0; i < MAX_PHYS; i++) begin : g_entry
    logic [PHY_AW-1:0] ent_q, ent_d;
    logic              ent_en;
    logic              fb_hit;

    if (i == 0) begin : g_fb
      assign fb_hit = fallback && (cnt_q == '0);
    end else begin : g_nofb
      assign fb_hit = 1'b0;
    end

    assign ent_en = clr || (push && (cnt_q == CW'(i))) || fb_hit;

    always_comb begin
      if (clr)
        ent_d = '0;
      else if (push && (cnt_q == CW'(i)))
        ent_d = push_addr;
      else
        ent_d = PHY_AW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ent_q <= '0;
      else if (ent_en)
        ent_q <= ent_d;
    end

    assign list[i*PHY_AW +: PHY_AW] = ent_q;
  end

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);
endmodule

// File: rtl/phy_scan_seq.sv
module phy_scan_seq
  import phy_scan_pkg::*;
#(
  parameter int MAX_PHYS = 4,
  parameter int DELAY_US = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [15:0]                  cfg_adv,
  input  logic                         force_en,
  input  logic                         force_spd100,
  input  logic                         force_fdx,
  input  logic                         expect_mii,
  input  logic                         us_tick,
  output logic                         mdio_req,
  output logic                         mdio_wr,
  output logic [4:0]                   mdio_phy,
  output logic [4:0]                   mdio_reg,
  output logic [15:0]                  mdio_wdata,
  input  logic                         mdio_ack,
  input  logic [15:0]                  mdio_rdata,
  output logic                         busy,
  output logic                         done,
  output logic [$clog2(MAX_PHYS+1)-1:0] phy_count,
  output logic [MAX_PHYS*5-1:0]        phy_list
);
  localparam int CW = $clog2(MAX_PHYS + 1);

  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  scan_state_e       state_q, state_d;
  logic [PHY_AW-1:0] addr_q, addr_d;
  logic [4:0]        stat_q, stat_d;
  logic [WORD_W-1:0] ctl_q, ctl_d, adv_q, adv_d;
  logic              done_q, done_d;
  logic              rd_en;

  logic [WORD_W-1:0] adv_new, ctl_new;
  logic              adv_need, ctl_need, an_flip;
  logic              tbl_clr, tbl_push, tbl_fb, tbl_full;
  logic              dly_load, dly_exp;

  phy_cfg_calc u_calc (
    .stat_hi(stat_q), .ctl_rd(ctl_q), .adv_rd(adv_q), .cfg_adv(cfg_adv),
    .force_en(force_en), .force_spd100(force_spd100), .force_fdx(force_fdx),
    .adv_out(adv_new), .adv_wr_need(adv_need), .ctl_out(ctl_new),
    .ctl_wr_need(ctl_need), .an_flip(an_flip)
  );

  phy_table #(.MAX_PHYS(MAX_PHYS), .CW(CW)) u_table (
    .clk(clk), .rst_n(rst_n_s), .clr(tbl_clr), .push(tbl_push),
    .push_addr(addr_q), .fallback(tbl_fb), .list(phy_list),
    .count(phy_count), .full(tbl_full)
  );

  phy_tick_delay #(.DELAY_US(DELAY_US)) u_delay (
    .clk(clk), .rst_n(rst_n_s), .load(dly_load), .tick(us_tick),
    .expired(dly_exp)
  );

  always_comb begin
    state_d    = state_q;
    addr_d     = addr_q;
    stat_d     = stat_q;
    ctl_d      = ctl_q;
    adv_d      = adv_q;
    done_d     = 1'b0;
    mdio_req   = 1'b0;
    mdio_wr    = 1'b0;
    mdio_reg   = REG_STAT;
    mdio_wdata = '0;
    tbl_clr    = 1'b0;
    tbl_push   = 1'b0;
    tbl_fb     = 1'b0;
    dly_load   = 1'b0;
    unique case (state_q)
      S_IDLE: if (start) begin
        tbl_clr = 1'b1;
        addr_d  = PHY_AW'(1);
        state_d = S_RD_STAT;
      end
      S_RD_STAT: begin
        mdio_req = 1'b1;
        if (mdio_ack) begin
          stat_d  = mdio_rdata[15:11];
          state_d = status_ok(mdio_rdata) ? S_RD_CTL : S_NEXT;
        end
      end
      S_RD_CTL: begin
        mdio_req = 1'b1;
        mdio_reg = REG_CTL;
        if (mdio_ack) begin
          ctl_d   = mdio_rdata;
          state_d = S_RD_ADV;
        end
      end
      S_RD_ADV: begin
        mdio_req = 1'b1;
        mdio_reg = REG_ADV;
        if (mdio_ack) begin
          adv_d   = mdio_rdata;
          state_d = S_DECIDE;
        end
      end
      S_DECIDE:
        state_d = adv_need ? S_WR_ADV : (ctl_need ? S_WR_CTL1 : S_RECORD);
      S_WR_ADV: begin
        mdio_req   = 1'b1;
        mdio_wr    = 1'b1;
        mdio_reg   = REG_ADV;
        mdio_wdata = adv_new;
        if (mdio_ack) state_d = ctl_need ? S_WR_CTL1 : S_RECORD;
      end
      S_WR_CTL1: begin
        mdio_req   = 1'b1;
        mdio_wr    = 1'b1;
        mdio_reg   = REG_CTL;
        mdio_wdata = ctl_new;
        if (mdio_ack) begin
          dly_load = an_flip;
          state_d  = an_flip ? S_WAIT : S_RECORD;
        end
      end
      S_WAIT: if (dly_exp) state_d = S_WR_CTL2;
      S_WR_CTL2: begin
        mdio_req   = 1'b1;
        mdio_wr    = 1'b1;
        mdio_reg   = REG_CTL;
        mdio_wdata = ctl_new;
        if (mdio_ack) state_d = S_RECORD;
      end
      S_RECORD: begin
        tbl_push = 1'b1;
        state_d  = S_NEXT;
      end
      S_NEXT:
        if (tbl_full || (addr_q == '0)) begin
          state_d = S_FINISH;
        end else begin
          addr_d  = addr_q + 1'b1;
          state_d = S_RD_STAT;
        end
      S_FINISH: begin
        tbl_fb  = expect_mii;
        done_d  = 1'b1;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  assign rd_en = mdio_ack && mdio_req && !mdio_wr;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      stat_q <= '0;
      ctl_q  <= '0;
      adv_q  <= '0;
    end else if (rd_en) begin
      stat_q <= stat_d;
      ctl_q  <= ctl_d;
      adv_q  <= adv_d;
    end
  end

  assign mdio_phy = addr_q;
  assign busy     = (state_q != S_IDLE);
  assign done     = done_q;

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n_s)
    mdio_req && !mdio_ack |=> mdio_req && $stable(mdio_wr) && $stable(mdio_phy)
      && $stable(mdio_reg) && $stable(mdio_wdata));
  p_reg_legal_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    mdio_req |-> (mdio_reg == REG_CTL || mdio_reg == REG_ADV ||
                  (mdio_reg == REG_STAT && !mdio_wr)));
  p_an_enable_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    mdio_req && mdio_wr && mdio_reg == REG_CTL && !force_en |-> mdio_wdata[CTL_AN_EN]);
  p_forced_bits_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    mdio_req && mdio_wr && mdio_reg == REG_CTL |->
      ((mdio_wdata & CTL_CLR_MASK & ~16'h2100) == '0) &&
      mdio_wdata[CTL_FDX] == force_fdx && mdio_wdata[CTL_SPD] == force_spd100 &&
      (!force_en || !mdio_wdata[CTL_AN_EN]));
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |=> !done);
  p_done_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |-> !mdio_req);
endmodule

// File: tb/phy_scan_seq_test.sv
module phy_scan_seq_test;
  localparam int MAXP  = 4;
  localparam int DLY   = 10;
  localparam int LAT   = 2;
  localparam int CW    = $clog2(MAXP + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] cfg_adv = '0;
  logic force_en = 1'b0, force_spd100 = 1'b0, force_fdx = 1'b0, expect_mii = 1'b0;
  logic us_tick = 1'b0;
  logic mdio_req, mdio_wr, mdio_ack = 1'b0;
  logic [4:0] mdio_phy, mdio_reg;
  logic [15:0] mdio_wdata, mdio_rdata = '0;
  logic busy, done;
  logic [CW-1:0] phy_count;
  logic [MAXP*5-1:0] phy_list;

  always #5 clk = ~clk;

  phy_scan_seq #(.MAX_PHYS(MAXP), .DELAY_US(DLY)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_adv(cfg_adv),
    .force_en(force_en), .force_spd100(force_spd100), .force_fdx(force_fdx),
    .expect_mii(expect_mii), .us_tick(us_tick), .mdio_req(mdio_req),
    .mdio_wr(mdio_wr), .mdio_phy(mdio_phy), .mdio_reg(mdio_reg),
    .mdio_wdata(mdio_wdata), .mdio_ack(mdio_ack), .mdio_rdata(mdio_rdata),
    .busy(busy), .done(done), .phy_count(phy_count), .phy_list(phy_list)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic [15:0] st_m [32];
  logic [15:0] ct_m [32];
  logic [15:0] ad_m [32];

  logic [26:0] exp_q [$];
  string       tag_q [$];
  int          exp_cnt;
  logic [4:0]  exp_list [MAXP];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // tick generator and tick counter
  int tdiv = 0;
  int tick_cnt = 0;
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    us_tick = (tdiv == 0);
  end
  always @(posedge clk) if (us_tick) tick_cnt++;

  // driver side: expected transaction queue
  task automatic push_exp(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                          input logic [15:0] d, input string tag);
    exp_q.push_back({wr, phy, rg, d});
    tag_q.push_back(tag);
  endtask

  task automatic ref_scan(input logic [15:0] cfg, input bit frc, input bit spd,
                          input bit fdx, input bit emii);
    logic [15:0] s, c, a, to, nc;
    bit tog;
    exp_cnt = 0;
    for (int i = 0; i < MAXP; i++) exp_list[i] = '0;
    for (int k = 0; k < 32; k++) begin
      logic [4:0] ad;
      ad = 5'((k + 1) % 32);
      if (exp_cnt == MAXP) break;
      s = st_m[ad];
      push_exp(0, ad, 5'd1, 16'h0, "R1");
      if (!(((s & 16'h8301) == 16'h8001) || (s[15] == 1'b0 && s[14:11] != 4'b0))) continue;
      c = ct_m[ad];
      a = ad_m[ad];
      push_exp(0, ad, 5'd0, 16'h0, "R3");
      push_exp(0, ad, 5'd4, 16'h0, "R3");
      if (a[8:5] == 4'b0) a = {6'd0, s[15:11], 4'd0, 1'b1};
      to = (cfg != 16'h0) ? cfg : a;
      if (to != a) push_exp(1, ad, 5'd4, to, "R4/R5");
      nc = c;
      nc[7] = 0; nc[10] = 0; nc[11] = 0; nc[14] = 0; nc[15] = 0;
      nc[8] = fdx; nc[13] = spd; nc[12] = !frc;
      tog = (c[12] != !frc);
      if (!frc && !c[12]) nc[9] = 1'b1;
      if (nc != c) begin
        push_exp(1, ad, 5'd0, nc, frc ? "R7" : "R6");
        if (tog) push_exp(1, ad, 5'd0, nc, "R8");
      end
      exp_list[exp_cnt] = ad;
      exp_cnt++;
    end
    if (exp_cnt == 0 && emii) exp_list[0] = 5'd1;
  endtask

  // monitor: responder and comparator
  int lat = 0;
  logic [41:0] snap;
  bit prev_ctl_wr = 0;
  logic [4:0] prev_phy;
  int prev_tick;
  always @(negedge clk) begin
    if (!rst_n) begin
      mdio_ack = 1'b0;
      lat = 0;
    end else if (mdio_ack) begin
      mdio_ack = 1'b0;
    end else if (mdio_req) begin
      if (lat == 0) snap = {mdio_wr, mdio_phy, mdio_reg, mdio_wdata, 15'd0};
      if (lat < LAT) lat++;
      else begin
        logic [26:0] act, ex;
        string tg;
        lat = 0;
        check(snap == {mdio_wr, mdio_phy, mdio_reg, mdio_wdata, 15'd0}, "R12 hold",
              32'(snap[41:15]), 32'({mdio_wr, mdio_phy, mdio_reg, mdio_wdata}));
        act = {mdio_wr, mdio_phy, mdio_reg, mdio_wr ? mdio_wdata : 16'h0};
        if (exp_q.size() == 0) begin
          check(0, "R1 unexpected transaction", 32'(act), 32'h0);
        end else begin
          ex = exp_q.pop_front();
          tg = tag_q.pop_front();
          check(act == ex, tg, 32'(act), 32'(ex));
        end
        if (mdio_wr && mdio_reg == 5'd0 && prev_ctl_wr && prev_phy == mdio_phy)
          check(tick_cnt - prev_tick >= DLY, "R8 gap", 32'(tick_cnt - prev_tick), 32'(DLY));
        prev_ctl_wr = mdio_wr && mdio_reg == 5'd0;
        prev_phy    = mdio_phy;
        prev_tick   = tick_cnt;
        if (mdio_wr) begin
          if (mdio_reg == 5'd0) ct_m[mdio_phy] = mdio_wdata;
          if (mdio_reg == 5'd4) ad_m[mdio_phy] = mdio_wdata;
          mdio_rdata = 16'h0;
        end else begin
          case (mdio_reg)
            5'd0: mdio_rdata = ct_m[mdio_phy];
            5'd1: mdio_rdata = st_m[mdio_phy];
            5'd4: mdio_rdata = ad_m[mdio_phy];
            default: mdio_rdata = 16'hFFFF;
          endcase
        end
        mdio_ack = 1'b1;
      end
    end
  end

  task automatic clear_phys();
    for (int i = 0; i < 32; i++) begin
      st_m[i] = 16'hFFFF; ct_m[i] = 16'hFFFF; ad_m[i] = 16'hFFFF;
    end
  endtask

  task automatic set_phy(input int a, input logic [15:0] s, input logic [15:0] c, input logic [15:0] v);
    st_m[a] = s; ct_m[a] = c; ad_m[a] = v;
  endtask

  task automatic run_scan(input string name, input logic [15:0] cfg, input bit frc,
                          input bit spd, input bit fdx, input bit emii, input bit restart_mid);
    cfg_adv = cfg; force_en = frc; force_spd100 = spd; force_fdx = fdx; expect_mii = emii;
    ref_scan(cfg, frc, spd, fdx, emii);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy == 1'b1, {name, " R11 busy"}, 32'(busy), 32'h1);
    if (restart_mid) begin
      repeat (60) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (!done) @(negedge clk);
    check(exp_q.size() == 0, {name, " R1/R9 all expected traffic seen"}, 32'(exp_q.size()), 32'h0);
    check(phy_count == CW'(exp_cnt), {name, " R9 count"}, 32'(phy_count), 32'(exp_cnt));
    for (int i = 0; i < MAXP; i++)
      check(phy_list[i*5 +: 5] == exp_list[i], {name, " R2/R9/R10 entry"},
            32'(phy_list[i*5 +: 5]), 32'(exp_list[i]));
    @(negedge clk);
    check(done == 1'b0, {name, " R11 done pulse"}, 32'(done), 32'h0);
    check(busy == 1'b0, {name, " R11 idle"}, 32'(busy), 32'h0);
    exp_q.delete(); tag_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    clear_phys();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(done == 1'b0 && mdio_req == 1'b0 && busy == 1'b0, "reset quiet",
          32'({done, mdio_req, busy}), 32'h0);
    check(phy_count == '0, "reset count", 32'(phy_count), 32'h0);

    // A: autonegotiation, derived advertisement, rejects, address 0, mid-scan start
    clear_phys();
    set_phy(1,  16'h7849, 16'h0000, 16'h01E1);
    set_phy(5,  16'h8001, 16'h1000, 16'h0001);
    set_phy(7,  16'h8301, 16'h0000, 16'h01E1);
    set_phy(9,  16'h7809, 16'h1100, 16'h01E1);
    set_phy(10, 16'h0009, 16'h0000, 16'h01E1);
    set_phy(0,  16'h782D, 16'h1200, 16'h0000);
    run_scan("A", 16'h0000, 0, 0, 0, 0, 1);

    // B: forced 100/full, override, table fills before address 0
    clear_phys();
    set_phy(2, 16'h7809, 16'h3100, 16'h05E1);
    set_phy(3, 16'h8001, 16'h2100, 16'h01E1);
    set_phy(4, 16'h0800, 16'h0400, 16'h0000);
    set_phy(6, 16'h7809, 16'h8000, 16'h05E1);
    set_phy(0, 16'h7809, 16'h0000, 16'h0000);
    run_scan("B", 16'h05E1, 1, 1, 0 == 1 ? 0 : 1, 0, 0);

    // C: nothing present, fallback requested
    clear_phys();
    run_scan("C", 16'h0000, 0, 0, 0, 1, 0);

    // D: nothing present, no fallback; table cleared by start
    run_scan("D", 16'h0000, 0, 0, 0, 0, 0);

    // E: configured value equal to derived advertisement, duplex in autoneg
    clear_phys();
    set_phy(3, 16'h8001, 16'h1000, 16'h0001);
    set_phy(4, 16'h7809, 16'h1000, 16'h0001);
    run_scan("E", 16'h0201, 0, 0, 1, 1, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule